// File: doc/BRIEF.md
# Infrared Remote Frame Decoder

This block turns the demodulated output of an infrared receiver into decoded remote-control key events. The receiver line is active low and already synchronized to the system clock, and a one-cycle enable arrives once per microsecond. The block measures how long each low burst and each high space lasts, in those microsecond ticks. It then compares each width against inclusive minimum/maximum windows, and follows the pulses through a fixed chain of phases: idle, preload (leader seen), user-code bits, data bits, and a repeat-sequence phase.

A complete frame is a leader burst and a leader space followed by 32 bits, sent least significant bit first: 16 user-code bits, 8 command bits, then 8 bits that must be the inverse of the command. A short trailing burst closes the frame. When the frame checks out, the block updates its code outputs and gives a one-cycle frame strobe. While a key is held down, the remote sends short repeat codes after timed gaps, and each accepted repeat gives a one-cycle repeat strobe. Every timing window is a parameter, and the defaults are in microseconds.

Top module: `nec_ir_decoder`

## Requirements
- R1: After reset, `user_code` and `command` are zero and both strobes are low.
- R2: A pulse width is the number of cycles with `tick_1us` high while the line holds one level. Cycles without a tick do not count. All windows are inclusive at both ends.
- R3: Frame reception starts only after a low leader burst of 8000 to 10000 ticks. A burst outside that window is not taken as a leader.
- R4: After the leader burst, a high space of 4000 to 5000 ticks starts bit reception. Any other width returns the decoder to idle.
- R5: Each bit is a low burst of 390 to 730 ticks followed by a high space. A space of 390 to 730 ticks is a 0 and a space of 1300 to 2000 ticks is a 1. Bits arrive least significant first: user code bits 0..15, then command bits 0..7, then inverted-command bits 0..7.
- R6: After the 32nd bit, if the inverted-command byte equals the bitwise NOT of the command byte, `user_code` and `command` take the new values and `frame_valid` is high for exactly one cycle. Otherwise there is no strobe and both outputs keep their old values. The code outputs change at no other time.
- R7: A bit burst or bit space outside its windows sends the decoder to idle, and that frame produces no strobe.
- R8: After a valid frame, a repeat code has four parts: the trailing burst (390 to 730 ticks low), a gap, a leader burst, and a 2000 to 2500 tick space. An accepted repeat code pulses `repeat_valid` for one cycle and leaves the code outputs unchanged.
- R9: The gap before the first repeat after a frame must last 95000 to 98000 ticks. The gap before each later repeat must last 30000 to 55000 ticks.
- R10: A gap outside its window, or a high level that runs beyond the gap maximum, sends the decoder to idle and gives no repeat strobe.
- R11: A repeat code with no valid frame before it gives no repeat strobe.
- R12: `frame_valid` and `repeat_valid` are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle enable, once per microsecond |
| ir_rx_n | input | 1 | Synchronized demodulated receiver line, low while a burst is present |
| user_code | output | 16 | User code of the last valid frame |
| command | output | 8 | Command byte of the last valid frame |
| frame_valid | output | 1 | One-cycle strobe for a newly accepted frame |
| repeat_valid | output | 1 | One-cycle strobe for an accepted repeat code |

## Verification
Two checks can fall in the same cycle: the silence limit in the gap phase and the edge that ends the gap. When the gap is one tick longer than its maximum, the running count passes the limit in the very cycle the edge is detected. The bench provokes this with gaps of exactly the maximum and one tick more, and then sends a repeat code. The repeat must be accepted for the first gap and rejected for the second.

// File: rtl/nec_ir_pkg.sv
`timescale 1ns/1ps
package nec_ir_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRELOAD,
        ST_USERCODE,
        ST_GETDATA,
        ST_SEQUENCE
    } dec_state_e;

    typedef enum logic [1:0] {
        SQ_TAIL,
        SQ_GAP,
        SQ_LEAD,
        SQ_SPACE
    } seq_phase_e;

    localparam int NUM_WIN = 8;

    // MSB first; the classifier fills hit_vec[7] .. hit_vec[0] in this order
    typedef struct packed {
        logic lead_low;
        logic frame_space;
        logic rpt_space;
        logic bit_low;
        logic bit0_high;
        logic bit1_high;
        logic gap_first;
        logic gap_later;
    } win_hits_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nec_pulse_timer.sv
`timescale 1ns/1ps
module nec_pulse_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ir_n,
    output logic             pulse_done,
    output logic             pulse_level,
    output logic [CNT_W-1:0] pulse_width,
    output logic [CNT_W-1:0] run_count
);

    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             edge_det;

    assign edge_det  = (ir_n != lvl_q);
    assign run_count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q       <= 1'b1;
            cnt_q       <= '0;
            pulse_done  <= 1'b0;
            pulse_level <= 1'b1;
            pulse_width <= '0;
        end else begin
            pulse_done <= edge_det;
            if (edge_det) begin
                pulse_level <= lvl_q;
                pulse_width <= cnt_q;
                lvl_q       <= ir_n;
                cnt_q       <= tick ? CNT_W'(1) : '0;
            end else if (tick && (cnt_q != '1)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_DONE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        pulse_done |-> (pulse_level != lvl_q)); // R2

    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q == '1) && !edge_det) |=> (cnt_q == '1)); // R2

    AST_NO_COUNT_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !edge_det) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/nec_window_classifier.sv
`timescale 1ns/1ps
module nec_window_classifier
    import nec_ir_pkg::*;
#(
    parameter int CNT_W            = 17,
    parameter int unsigned LEAD_LOW_MIN    = 8000,
    parameter int unsigned LEAD_LOW_MAX    = 10000,
    parameter int unsigned FRAME_SPACE_MIN = 4000,
    parameter int unsigned FRAME_SPACE_MAX = 5000,
    parameter int unsigned RPT_SPACE_MIN   = 2000,
    parameter int unsigned RPT_SPACE_MAX   = 2500,
    parameter int unsigned BIT_LOW_MIN     = 390,
    parameter int unsigned BIT_LOW_MAX     = 730,
    parameter int unsigned BIT0_HIGH_MIN   = 390,
    parameter int unsigned BIT0_HIGH_MAX   = 730,
    parameter int unsigned BIT1_HIGH_MIN   = 1300,
    parameter int unsigned BIT1_HIGH_MAX   = 2000,
    parameter int unsigned GAP_FIRST_MIN   = 95000,
    parameter int unsigned GAP_FIRST_MAX   = 98000,
    parameter int unsigned GAP_LATER_MIN   = 30000,
    parameter int unsigned GAP_LATER_MAX   = 55000
) (
    input  logic [CNT_W-1:0] width,
    output win_hits_t        hits
);

    localparam logic [31:0] WIN_LO [NUM_WIN] = '{
        32'(GAP_LATER_MIN), 32'(GAP_FIRST_MIN), 32'(BIT1_HIGH_MIN), 32'(BIT0_HIGH_MIN),
        32'(BIT_LOW_MIN), 32'(RPT_SPACE_MIN), 32'(FRAME_SPACE_MIN), 32'(LEAD_LOW_MIN)};
    localparam logic [31:0] WIN_HI [NUM_WIN] = '{
        32'(GAP_LATER_MAX), 32'(GAP_FIRST_MAX), 32'(BIT1_HIGH_MAX), 32'(BIT0_HIGH_MAX),
        32'(BIT_LOW_MAX), 32'(RPT_SPACE_MAX), 32'(FRAME_SPACE_MAX), 32'(LEAD_LOW_MAX)};

    logic [31:0]        width_ext;
    logic [NUM_WIN-1:0] hit_vec;

    assign width_ext = {{(32-CNT_W){1'b0}}, width};

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign hit_vec[i] = (width_ext >= WIN_LO[i]) && (width_ext <= WIN_HI[i]);
    end

    assign hits = win_hits_t'(hit_vec);

endmodule

// File: rtl/nec_frame_fsm.sv
`timescale 1ns/1ps
module nec_frame_fsm
    import nec_ir_pkg::*;
#(
    parameter int CNT_W                 = 17,
    parameter int USER_BITS             = 16,
    parameter int CMD_BITS              = 8,
    parameter int unsigned LEAD_LOW_MAX  = 10000,
    parameter int unsigned GAP_FIRST_MAX = 98000,
    parameter int unsigned GAP_LATER_MAX = 55000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pulse_done,
    input  logic                 pulse_level,
    input  win_hits_t            hits,
    input  logic [CNT_W-1:0]     run_count,
    output logic [USER_BITS-1:0] user_code,
    output logic [CMD_BITS-1:0]  command,
    output logic                 frame_valid,
    output logic                 repeat_valid
);

    localparam int FRAME_BITS = USER_BITS + 2 * CMD_BITS;
    localparam int BC_W       = $clog2(FRAME_BITS + 1);

    dec_state_e              state;
    seq_phase_e              seq;
    logic                    want_high;
    logic                    first_gap;
    logic [BC_W-1:0]         bit_cnt;
    logic [FRAME_BITS-1:0]   shift_q;
    logic [FRAME_BITS-1:0]   shift_nx;
    logic [CMD_BITS-1:0]     nx_cmd;
    logic [CMD_BITS-1:0]     nx_inv;
    logic                    check_ok;
    logic                    last_bit;
    logic [31:0]             limit;
    logic                    timeout;
    logic                    gap_ok;

    assign shift_nx = {hits.bit1_high, shift_q[FRAME_BITS-1:1]};
    assign nx_cmd   = shift_nx[USER_BITS +: CMD_BITS];
    assign nx_inv   = shift_nx[USER_BITS+CMD_BITS +: CMD_BITS];
    assign check_ok = (nx_cmd == ~nx_inv);
    assign last_bit = (bit_cnt == BC_W'(FRAME_BITS - 1));
    assign gap_ok   = first_gap ? hits.gap_first : hits.gap_later;

    always_comb begin
        if ((state == ST_SEQUENCE) && (seq == SQ_GAP))
            limit = first_gap ? 32'(GAP_FIRST_MAX) : 32'(GAP_LATER_MAX);
        else
            limit = 32'(LEAD_LOW_MAX);
        timeout = (state != ST_IDLE) && ({{(32-CNT_W){1'b0}}, run_count} > limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            seq          <= SQ_TAIL;
            want_high    <= 1'b0;
            first_gap    <= 1'b0;
            bit_cnt      <= '0;
            shift_q      <= '0;
            user_code    <= '0;
            command      <= '0;
            frame_valid  <= 1'b0;
            repeat_valid <= 1'b0;
        end else begin
            frame_valid  <= 1'b0;
            repeat_valid <= 1'b0;
            if (timeout) begin
                state <= ST_IDLE;
            end else if (pulse_done) begin
                case (state)
                    ST_IDLE: begin
                        if (!pulse_level && hits.lead_low)
                            state <= ST_PRELOAD;
                    end
                    ST_PRELOAD: begin
                        if (pulse_level && hits.frame_space) begin
                            state     <= ST_USERCODE;
                            bit_cnt   <= '0;
                            want_high <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_USERCODE, ST_GETDATA: begin
                        if (!want_high) begin
                            if (!pulse_level && hits.bit_low)
                                want_high <= 1'b1;
                            else
                                state <= ST_IDLE;
                        end else if (pulse_level && (hits.bit0_high || hits.bit1_high)) begin
                            shift_q   <= shift_nx;
                            bit_cnt   <= bit_cnt + BC_W'(1);
                            want_high <= 1'b0;
                            if (last_bit) begin
                                if (check_ok) begin
                                    user_code   <= shift_nx[USER_BITS-1:0];
                                    command     <= nx_cmd;
                                    frame_valid <= 1'b1;
                                    state       <= ST_SEQUENCE;
                                    seq         <= SQ_TAIL;
                                    first_gap   <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (bit_cnt == BC_W'(USER_BITS - 1)) begin
                                state <= ST_GETDATA;
                            end
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_SEQUENCE: begin
                        case (seq)
                            SQ_TAIL: begin
                                if (!pulse_level && hits.bit_low) seq <= SQ_GAP;
                                else state <= ST_IDLE;
                            end
                            SQ_GAP: begin
                                if (pulse_level && gap_ok) seq <= SQ_LEAD;
                                else state <= ST_IDLE;
                            end
                            SQ_LEAD: begin
                                if (!pulse_level && hits.lead_low) seq <= SQ_SPACE;
                                else state <= ST_IDLE;
                            end
                            default: begin
                                if (pulse_level && hits.rpt_space) begin
                                    repeat_valid <= 1'b1;
                                    first_gap    <= 1'b0;
                                    seq          <= SQ_TAIL;
                                end else if (pulse_level && hits.frame_space) begin
                                    state     <= ST_USERCODE;
                                    bit_cnt   <= '0;
                                    want_high <= 1'b0;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        endcase
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_valid, repeat_valid})); // R12

    AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid); // R12

    AST_REPEAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        repeat_valid |=> !repeat_valid); // R12

    AST_CODE_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        ((user_code != $past(user_code)) || (command != $past(command))) |-> frame_valid); // R6

    AST_REPEAT_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
        repeat_valid |-> ($stable(user_code) && $stable(command))); // R8

    AST_FRAME_COMPLEMENT_SEEN: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (state == ST_SEQUENCE)); // R6

endmodule

// File: rtl/nec_ir_decoder.sv
`timescale 1ns/1ps
module nec_ir_decoder
    import nec_ir_pkg::*;
#(
    parameter int USER_BITS                 = 16,
    parameter int CMD_BITS                  = 8,
    parameter int unsigned LEAD_LOW_MIN     = 8000,
    parameter int unsigned LEAD_LOW_MAX     = 10000,
    parameter int unsigned FRAME_SPACE_MIN  = 4000,
    parameter int unsigned FRAME_SPACE_MAX  = 5000,
    parameter int unsigned RPT_SPACE_MIN    = 2000,
    parameter int unsigned RPT_SPACE_MAX    = 2500,
    parameter int unsigned BIT_LOW_MIN      = 390,
    parameter int unsigned BIT_LOW_MAX      = 730,
    parameter int unsigned BIT0_HIGH_MIN    = 390,
    parameter int unsigned BIT0_HIGH_MAX    = 730,
    parameter int unsigned BIT1_HIGH_MIN    = 1300,
    parameter int unsigned BIT1_HIGH_MAX    = 2000,
    parameter int unsigned GAP_FIRST_MIN    = 95000,
    parameter int unsigned GAP_FIRST_MAX    = 98000,
    parameter int unsigned GAP_LATER_MIN    = 30000,
    parameter int unsigned GAP_LATER_MAX    = 55000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_1us,
    input  logic                 ir_rx_n,
    output logic [USER_BITS-1:0] user_code,
    output logic [CMD_BITS-1:0]  command,
    output logic                 frame_valid,
    output logic                 repeat_valid
);

    localparam int unsigned LONGEST =
        umax(umax(GAP_FIRST_MAX, GAP_LATER_MAX), umax(LEAD_LOW_MAX, FRAME_SPACE_MAX));
    localparam int CNT_W = $clog2(LONGEST + 2);

    logic             pulse_done;
    logic             pulse_level;
    logic [CNT_W-1:0] pulse_width;
    logic [CNT_W-1:0] run_count;
    win_hits_t        hits;

    nec_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_1us),
        .ir_n        (ir_rx_n),
        .pulse_done  (pulse_done),
        .pulse_level (pulse_level),
        .pulse_width (pulse_width),
        .run_count   (run_count)
    );

    nec_window_classifier #(
        .CNT_W           (CNT_W),
        .LEAD_LOW_MIN    (LEAD_LOW_MIN),
        .LEAD_LOW_MAX    (LEAD_LOW_MAX),
        .FRAME_SPACE_MIN (FRAME_SPACE_MIN),
        .FRAME_SPACE_MAX (FRAME_SPACE_MAX),
        .RPT_SPACE_MIN   (RPT_SPACE_MIN),
        .RPT_SPACE_MAX   (RPT_SPACE_MAX),
        .BIT_LOW_MIN     (BIT_LOW_MIN),
        .BIT_LOW_MAX     (BIT_LOW_MAX),
        .BIT0_HIGH_MIN   (BIT0_HIGH_MIN),
        .BIT0_HIGH_MAX   (BIT0_HIGH_MAX),
        .BIT1_HIGH_MIN   (BIT1_HIGH_MIN),
        .BIT1_HIGH_MAX   (BIT1_HIGH_MAX),
        .GAP_FIRST_MIN   (GAP_FIRST_MIN),
        .GAP_FIRST_MAX   (GAP_FIRST_MAX),
        .GAP_LATER_MIN   (GAP_LATER_MIN),
        .GAP_LATER_MAX   (GAP_LATER_MAX)
    ) u_classify (
        .width (pulse_width),
        .hits  (hits)
    );

    nec_frame_fsm #(
        .CNT_W         (CNT_W),
        .USER_BITS     (USER_BITS),
        .CMD_BITS      (CMD_BITS),
        .LEAD_LOW_MAX  (LEAD_LOW_MAX),
        .GAP_FIRST_MAX (GAP_FIRST_MAX),
        .GAP_LATER_MAX (GAP_LATER_MAX)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pulse_done   (pulse_done),
        .pulse_level  (pulse_level),
        .hits         (hits),
        .run_count    (run_count),
        .user_code    (user_code),
        .command      (command),
        .frame_valid  (frame_valid),
        .repeat_valid (repeat_valid)
    );

endmodule

// File: tb/test_nec_ir_decoder.sv
`timescale 1ns/1ps
module test_nec_ir_decoder;

    // Windows scaled down by ten so the whole run stays short
    localparam int LL_MIN = 800,  LL_MAX = 1000;
    localparam int FS_MIN = 400,  FS_MAX = 500;
    localparam int RS_MIN = 200,  RS_MAX = 250;
    localparam int GF_MIN = 9500, GF_MAX = 9800;
    localparam int GL_MIN = 3000, GL_MAX = 5500;
    localparam int BURST = 56, ZERO_SP = 56, ONE_SP = 169;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        slow = 1'b0;
    logic        ir_n = 1'b1;
    logic [15:0] user_code;
    logic [7:0]  command;
    logic        frame_valid;
    logic        repeat_valid;

    int compared = 0;
    int mismatched = 0;
    int fcnt = 0;
    int rcnt = 0;
    int both_cnt = 0;
    int long_cnt = 0;
    int cycles = 0;
    logic fv_d = 1'b0;
    logic rv_d = 1'b0;

    always #10 clk = ~clk;

    nec_ir_decoder #(
        .LEAD_LOW_MIN(LL_MIN), .LEAD_LOW_MAX(LL_MAX),
        .FRAME_SPACE_MIN(FS_MIN), .FRAME_SPACE_MAX(FS_MAX),
        .RPT_SPACE_MIN(RS_MIN), .RPT_SPACE_MAX(RS_MAX),
        .BIT_LOW_MIN(39), .BIT_LOW_MAX(73),
        .BIT0_HIGH_MIN(39), .BIT0_HIGH_MAX(73),
        .BIT1_HIGH_MIN(130), .BIT1_HIGH_MAX(200),
        .GAP_FIRST_MIN(GF_MIN), .GAP_FIRST_MAX(GF_MAX),
        .GAP_LATER_MIN(GL_MIN), .GAP_LATER_MAX(GL_MAX)
    ) i_nec_ir_decoder (
        .clk(clk), .rst(rst), .tick_1us(tick), .ir_rx_n(ir_n),
        .user_code(user_code), .command(command),
        .frame_valid(frame_valid), .repeat_valid(repeat_valid)
    );

    always @(negedge clk) tick <= slow ? ~tick : 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (frame_valid) fcnt++;
            if (repeat_valid) rcnt++;
            if (frame_valid && repeat_valid) both_cnt++;
            if ((frame_valid && fv_d) || (repeat_valid && rv_d)) long_cnt++;
        end
        fv_d <= frame_valid;
        rv_d <= repeat_valid;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic phase(input logic lvl, input int n);
        int k;
        @(negedge clk);
        ir_n = lvl;
        k = 0;
        while (k < n) begin
            @(posedge clk);
            #1;
            if (tick) k++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ir_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input logic [15:0] u, input logic [7:0] c, input logic [7:0] ci,
                              input int lead, input int space, input int bad_bit, input int gap);
        logic [31:0] word;
        word = {ci, c, u};
        phase(1'b0, lead);
        phase(1'b1, space);
        for (int i = 0; i < 32; i++) begin
            phase(1'b0, BURST);
            phase(1'b1, (i == bad_bit) ? 100 : (word[i] ? ONE_SP : ZERO_SP));
        end
        phase(1'b0, BURST);
        phase(1'b1, gap);
    endtask

    task automatic send_repeat(input int space, input int gap);
        phase(1'b0, 900);
        phase(1'b1, space);
        phase(1'b0, BURST);
        phase(1'b1, gap);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 user_code", 32'(user_code), 32'h0);
        check("R1 command", 32'(command), 32'h0);
        check("R1 strobes", {30'd0, frame_valid, repeat_valid}, 32'h0);
    endtask

    task automatic t_basic_frame();
        int f0;
        do_reset();
        f0 = fcnt;
        send_frame(16'hA55A, 8'h3C, 8'hC3, LL_MIN, 450, -1, 20);
        check("R3 R6 frame strobe at leader minimum", 32'(fcnt - f0), 32'd1);
        check("R5 user_code", 32'(user_code), 32'hA55A);
        check("R5 command", 32'(command), 32'h3C);
    endtask

    task automatic t_repeats_then_bad_complement();
        int f0, r0;
        do_reset();
        f0 = fcnt; r0 = rcnt;
        send_frame(16'h1234, 8'hA7, 8'h58, LL_MAX, FS_MAX, -1, 9600);
        send_repeat(225, 4000);
        send_repeat(RS_MAX, 50);
        check("R8 R9 repeat strobes", 32'(rcnt - r0), 32'd2);
        check("R8 user_code kept", 32'(user_code), 32'h1234);
        check("R8 command kept", 32'(command), 32'hA7);
        f0 = fcnt;
        send_frame(16'h0F0F, 8'h12, 8'h12, 900, 450, -1, 20);
        check("R6 no strobe on bad complement", 32'(fcnt - f0), 32'd0);
        check("R6 user_code unchanged", 32'(user_code), 32'h1234);
        check("R6 command unchanged", 32'(command), 32'hA7);
    endtask

    task automatic t_corrupt_bit();
        int f0;
        do_reset();
        f0 = fcnt;
        send_frame(16'h00FF, 8'h01, 8'hFE, 900, 450, 20, 20);
        check("R7 no strobe after bad bit space", 32'(fcnt - f0), 32'd0);
        check("R7 user_code unchanged", 32'(user_code), 32'h0);
    endtask

    task automatic t_leader_bounds();
        int f0;
        do_reset();
        f0 = fcnt;
        send_frame(16'h0000, 8'h00, 8'hFF, LL_MIN - 1, 450, -1, 20);
        check("R3 short leader rejected", 32'(fcnt - f0), 32'd0);
        do_reset();
        send_frame(16'h0000, 8'h00, 8'hFF, LL_MAX + 1, 450, -1, 20);
        check("R3 long leader rejected", 32'(fcnt - f0), 32'd0);
        do_reset();
        send_frame(16'h0000, 8'h00, 8'hFF, 900, FS_MAX + 1, -1, 20);
        check("R4 long leader space rejected", 32'(fcnt - f0), 32'd0);
    endtask

    task automatic t_repeat_from_idle();
        int r0;
        do_reset();
        r0 = rcnt;
        send_repeat(225, 50);
        check("R11 no repeat without frame", 32'(rcnt - r0), 32'd0);
    endtask

    task automatic t_gap_window();
        int r0;
        do_reset();
        r0 = rcnt;
        send_frame(16'h0001, 8'h80, 8'h7F, 900, 450, -1, GF_MIN - 500);
        send_repeat(225, 50);
        check("R10 short first gap rejected", 32'(rcnt - r0), 32'd0);
    endtask

    task automatic t_gap_edge();
        int r0;
        do_reset();
        r0 = rcnt;
        send_frame(16'h0002, 8'h40, 8'hBF, 900, 450, -1, GF_MAX);
        send_repeat(225, 50);
        check("R9 gap at maximum accepted", 32'(rcnt - r0), 32'd1);
        do_reset();
        r0 = rcnt;
        send_frame(16'h0002, 8'h40, 8'hBF, 900, 450, -1, GF_MAX + 1);
        send_repeat(225, 50);
        check("R10 gap one past maximum rejected", 32'(rcnt - r0), 32'd0);
    endtask

    task automatic t_slow_tick();
        int f0;
        do_reset();
        slow = 1'b1;
        f0 = fcnt;
        send_frame(16'h8001, 8'h01, 8'hFE, 900, 450, -1, 20);
        slow = 1'b0;
        check("R2 frame counted in ticks", 32'(fcnt - f0), 32'd1);
        check("R2 user_code", 32'(user_code), 32'h8001);
        check("R2 command", 32'(command), 32'h01);
    endtask

    initial begin : watchdog
        while (cycles < 195000) begin
            @(posedge clk);
            cycles++;
        end
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 195000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        t_reset();
        t_basic_frame();
        t_repeats_then_bad_complement();
        t_corrupt_bit();
        t_leader_bounds();
        t_repeat_from_idle();
        t_gap_window();
        t_gap_edge();
        t_slow_tick();
        check("R12 strobes in same cycle", 32'(both_cnt), 32'd0);
        check("R12 strobes longer than one cycle", 32'(long_cnt), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule